// File: doc/BRIEF.md
# Wavetable Sample Memory with Shared CPU Port

This block stores the waveform of a wavetable sound channel: sixteen bytes holding thirty-two four-bit samples, two per byte. The playback engine presents a sample position and receives the matching nibble at once. A processor reaches the same bytes through a byte-wide read/write port.

While the channel is idle, the processor addresses bytes directly. Once playback runs, the processor no longer picks the byte. Its accesses land on the byte the engine is currently playing. In legacy mode this is allowed only while the engine reports that a short access window is open. Outside that window, writes are lost and reads return all ones. Enhanced mode relaxes this: writes always follow the processor address, and reads are always redirected to the playing byte.

Top module: `wave_sample_port`

## Requirements
- R1: Reset (rstN low) clears all sixteen bytes and the read data register to 0x00.
- R2: When `playing` is low, a write stores `cpuWrData` at byte `cpuAddr`, and a read returns byte `cpuAddr`.
- R3: When `playing` is high, `enhancedMode` is low and `readWindow` is high, a write stores its data at byte `samplePos>>1`, whatever `cpuAddr` holds.
- R4: When `playing` is high and both `enhancedMode` and `readWindow` are low, a write changes no byte.
- R5: When `enhancedMode` is high, a write stores at byte `cpuAddr` even while `playing` is high.
- R6: When `playing` is high and either `readWindow` or `enhancedMode` is high, a read returns byte `samplePos>>1`.
- R7: When `playing` is high and both `readWindow` and `enhancedMode` are low, a read returns 0xFF.
- R8: `sampleOut` follows `samplePos` with no clock delay. An even position gives bits 7:4 of byte `samplePos>>1`, and an odd position gives bits 3:0.
- R9: `cpuRdData` updates on the clock edge that samples `cpuRd` high, is valid the cycle after, and holds its value in cycles with `cpuRd` low.
- R10: A read and a write to the same byte in the same cycle return the byte's content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuAddr | input | 4 | Processor byte address |
| cpuWrData | input | 8 | Processor write data |
| cpuRd | input | 1 | Processor read strobe |
| cpuWr | input | 1 | Processor write strobe |
| playing | input | 1 | Channel playback running |
| samplePos | input | 5 | Current playback sample position |
| readWindow | input | 1 | Legacy access window open |
| enhancedMode | input | 1 | 1 selects enhanced behaviour, 0 selects legacy |
| cpuRdData | output | 8 | Registered processor read data |
| sampleOut | output | 4 | Sample nibble at the playback position |

## Verification
The hardest case to reach is a legacy write during playback. Here the target byte comes from the sample position and not from the address, so a wrong choice of byte can go unseen. The stimulus therefore drives a processor address that differs from the playing byte for all thirty-two positions. It then reads the memory back while the channel is idle, so both the byte that should change and the bytes that should not are visible at the ports. Dropped writes are checked the same way: each one is followed by an idle read-back of the byte the engine was playing.

// File: rtl/wave_pkg.sv
package wave_pkg;
  typedef struct packed {
    logic wrEn;      // commit a write this cycle
    logic wrUsePos;  // write index from playback position
    logic rdEn;      // capture read data this cycle
    logic rdUsePos;  // read index from playback position
    logic rdBlank;   // return all ones instead of memory
  } wave_ctrl_t;
endpackage

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wave_pkg::*;
(
  input  logic       cpuRd,
  input  logic       cpuWr,
  input  logic       playing,
  input  logic       readWindow,
  input  logic       enhancedMode,
  output wave_ctrl_t ctrl
);
  logic legacyPlay;

  always_comb begin
    legacyPlay    = playing && !enhancedMode;
    ctrl.wrEn     = cpuWr && (!legacyPlay || readWindow);
    ctrl.wrUsePos = legacyPlay;
    ctrl.rdEn     = cpuRd;
    ctrl.rdUsePos = playing;
    ctrl.rdBlank  = legacyPlay && !readWindow;
  end
endmodule

// File: rtl/wave_nibble_sel.sv
module wave_nibble_sel #(
  parameter int DATA_W = 8,
  parameter int SAMPLES_PER_BYTE = 2,
  localparam int NIB_W = DATA_W / SAMPLES_PER_BYTE,
  localparam int SEL_W = (SAMPLES_PER_BYTE > 1) ? $clog2(SAMPLES_PER_BYTE) : 1
) (
  input  logic [DATA_W-1:0] byteIn,
  input  logic [SEL_W-1:0]  sel,
  output logic [NIB_W-1:0]  nibble
);
  logic [NIB_W-1:0] slots [SAMPLES_PER_BYTE];

  // slot 0 is the most significant nibble: earlier samples sit higher
  for (genvar s = 0; s < SAMPLES_PER_BYTE; s++) begin : g_slot
    assign slots[s] = byteIn[DATA_W-1-s*NIB_W -: NIB_W];
  end

  assign nibble = slots[sel];
endmodule

// File: rtl/wave_dp.sv
module wave_dp
  import wave_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int POS_W = ADDR_W + 1,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wave_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [POS_W-1:0]  samplePos,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [NIB_W-1:0]  sampleOut
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] posByte;
  logic [ADDR_W-1:0] wrIdx;
  logic [ADDR_W-1:0] rdIdx;
  logic [DATA_W-1:0] rdNext;

  assign posByte = samplePos[POS_W-1:1];

  always_comb begin
    wrIdx  = ctrl.wrUsePos ? posByte : cpuAddr;
    rdIdx  = ctrl.rdUsePos ? posByte : cpuAddr;
    rdNext = ctrl.rdBlank ? {DATA_W{1'b1}} : mem[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cpuRdData <= '0;
    end else begin
      if (ctrl.wrEn) mem[wrIdx] <= cpuWrData;
      if (ctrl.rdEn) cpuRdData <= rdNext;
    end
  end

  wave_nibble_sel #(.DATA_W(DATA_W), .SAMPLES_PER_BYTE(2)) u_nib (
    .byteIn(mem[posByte]),
    .sel   (samplePos[0]),
    .nibble(sampleOut)
  );
endmodule

// File: rtl/wave_sample_port.sv
module wave_sample_port
  import wave_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int POS_W = ADDR_W + 1,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              playing,
  input  logic [POS_W-1:0]  samplePos,
  input  logic              readWindow,
  input  logic              enhancedMode,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [NIB_W-1:0]  sampleOut
);
  wave_ctrl_t ctrl;

  wave_ctrl u_ctrl (
    .cpuRd       (cpuRd),
    .cpuWr       (cpuWr),
    .playing     (playing),
    .readWindow  (readWindow),
    .enhancedMode(enhancedMode),
    .ctrl        (ctrl)
  );

  wave_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cpuAddr  (cpuAddr),
    .cpuWrData(cpuWrData),
    .samplePos(samplePos),
    .cpuRdData(cpuRdData),
    .sampleOut(sampleOut)
  );
endmodule

// File: rtl/wave_sample_port_chk.sv
module wave_sample_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int POS_W = ADDR_W + 1,
  localparam int NIB_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic              playing,
  input logic [POS_W-1:0]  samplePos,
  input logic              readWindow,
  input logic              enhancedMode,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [NIB_W-1:0]  sampleOut
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> cpuRdData == '0);

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> $stable(cpuRdData));

  assert_blank_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuRd && playing && !enhancedMode && !readWindow |=> cpuRdData == {DATA_W{1'b1}});

  assert_dropped_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr && playing && !enhancedMode && !readWindow |=>
      (samplePos != $past(samplePos)) || (sampleOut == $past(sampleOut)));

  assert_redirect_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr && playing && !enhancedMode && readWindow |=>
      (samplePos != $past(samplePos)) ||
      (sampleOut == ($past(samplePos[0]) ? $past(cpuWrData[NIB_W-1:0])
                                         : $past(cpuWrData[DATA_W-1:NIB_W]))));
endmodule

bind wave_sample_port wave_sample_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuWrData   (cpuWrData),
  .cpuRd       (cpuRd),
  .cpuWr       (cpuWr),
  .playing     (playing),
  .samplePos   (samplePos),
  .readWindow  (readWindow),
  .enhancedMode(enhancedMode),
  .cpuRdData   (cpuRdData),
  .sampleOut   (sampleOut)
);

// File: tb/wave_sample_port_tb.sv
module wave_sample_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic       cpuRd = 1'b0;
  logic       cpuWr = 1'b0;
  logic       playing = 1'b0;
  logic [4:0] samplePos = '0;
  logic       readWindow = 1'b0;
  logic       enhancedMode = 1'b0;
  logic [7:0] cpuRdData;
  logic [3:0] sampleOut;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] model [16];
  logic [7:0] lastRd = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wave_sample_port u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .playing(playing), .samplePos(samplePos),
    .readWindow(readWindow), .enhancedMode(enhancedMode),
    .cpuRdData(cpuRdData), .sampleOut(sampleOut)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [4:0] p);
    return p[0] ? model[p[4:1]][3:0] : model[p[4:1]][7:4];
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic op(input logic rd, input logic wr, input logic [3:0] a,
                    input logic [7:0] d, input logic play, input logic [4:0] p,
                    input logic win, input logic enh, input string req);
    logic [7:0] exp;
    logic       legacy;
    legacy = play && !enh;
    if (!play) exp = model[a];
    else if (win || enh) exp = model[p[4:1]];
    else exp = 8'hFF;
    cpuRd = rd; cpuWr = wr; cpuAddr = a; cpuWrData = d;
    playing = play; samplePos = p; readWindow = win; enhancedMode = enh;
    @(posedge clk);
    @(negedge clk);
    if (wr) begin
      if (!legacy) model[a] = d;
      else if (win) model[p[4:1]] = d;
    end
    cpuRd = 1'b0; cpuWr = 1'b0;
    if (rd) begin
      check(cpuRdData, exp, req);
      lastRd = exp;
    end else begin
      check(cpuRdData, lastRd, "R9 hold");
    end
    check({4'h0, sampleOut}, {4'h0, nib(p)}, "R8 nibble");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuRdData, 8'h00, "R1 read reg");
    for (int p = 0; p < 32; p++) begin
      samplePos = 5'(p); #1;
      check({4'h0, sampleOut}, 8'h00, "R1 nibble clear");
    end
    @(negedge clk);
    for (int a = 0; a < 16; a++) op(1, 0, 4'(a), 8'h00, 0, 0, 0, 0, "R1 byte clear");

    // R2 idle direct writes and reads
    for (int a = 0; a < 16; a++) op(0, 1, 4'(a), 8'(a * 37 + 5), 0, 0, 0, 0, "R2 write");
    for (int a = 0; a < 16; a++) op(1, 0, 4'(a), 8'h00, 0, 0, 0, 0, "R2 read");

    // R8 nibble sweep, combinational
    for (int p = 0; p < 32; p++) begin
      samplePos = 5'(p); #1;
      check({4'h0, sampleOut}, {4'h0, nib(5'(p))}, "R8 sweep");
    end
    @(negedge clk);

    // R3 legacy redirected writes, R6 redirected reads
    for (int p = 0; p < 32; p++) begin
      op(0, 1, 4'(15 - p[4:1]) ^ 4'h5, 8'(p * 11 + 3), 1, 5'(p), 1, 0, "R3 redirect");
      op(1, 0, 4'(p * 3), 8'h00, 1, 5'(p), 1, 0, "R6 legacy window read");
    end
    for (int a = 0; a < 16; a++) op(1, 0, 4'(a), 8'h00, 0, 0, 0, 0, "R3 readback");

    // R4 dropped writes, R7 blank reads
    for (int p = 0; p < 32; p++) begin
      op(0, 1, 4'(p[4:1]), 8'h5A, 1, 5'(p), 0, 0, "R4 drop");
      op(1, 0, 4'(p[4:1]), 8'h00, 1, 5'(p), 0, 0, "R7 blank");
      op(1, 0, 4'(p[4:1]), 8'h00, 0, 0, 0, 0, "R4 readback");
    end

    // R5 enhanced writes by address, R6 enhanced reads by position
    for (int a = 0; a < 16; a++) begin
      op(0, 1, 4'(a), 8'(a) ^ 8'hC3, 1, 5'(a * 5), 0, 1, "R5 enhanced write");
      op(1, 0, 4'(a + 7), 8'h00, 1, 5'(a * 9), 0, 1, "R6 enhanced read");
    end
    for (int a = 0; a < 16; a++) op(1, 0, 4'(a), 8'h00, 0, 0, 0, 0, "R5 readback");

    // R10 read and write same byte same cycle
    for (int a = 0; a < 16; a += 3) begin
      op(1, 1, 4'(a), 8'(a * 17 + 1), 0, 0, 0, 0, "R10 old value");
      op(1, 0, 4'(a), 8'h00, 0, 0, 0, 0, "R10 new value");
    end
    op(1, 1, 4'd4, 8'hE7, 1, 5'd9, 1, 0, "R10 legacy window");
    op(1, 0, 4'd0, 8'h00, 1, 5'd9, 1, 0, "R10 legacy new value");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule